// File: doc/BRIEF.md
# I2C Channel-Select Mux Controller

This block is an I2C slave that steers one of four downstream bus channels and merges four active-low interrupt lines into one. SCL and SDA are sampled on the system clock through a short synchroniser. SDA is driven only as an open-drain pull-down enable. The 7-bit slave address has a fixed upper nibble, set by a parameter, and three low bits taken from strap pins.

A write stores a control value, and only its three low bits are kept. The new selection stays pending until the next STOP. Only then does it reach the four one-hot channel enables, so a channel is never connected in the middle of a transfer. A read returns a status byte. Its upper nibble is the asserted state of the four interrupt inputs, and its low three bits are the stored control value. The combined interrupt output is low whenever any input is low, whatever channel is selected.

Top module: `i2c_chsel_ctrl`

## Requirements
- R1: A START (SDA falls while SCL is high) begins address reception. The slave ACKs the ninth clock, with SDA pulled low, only when the first seven received bits equal {ADDR_HI, strap_i}. Otherwise it leaves SDA released.
- R2: After an address match with R/W = 0, every received data byte is acknowledged by pulling SDA low during its ninth clock.
- R3: When one transaction writes several bytes, only the last byte's selection is kept.
- R4: A written selection changes ch_en_o only after the next STOP (SDA rises while SCL is high), not when the byte is received.
- R5: While reset is applied, ch_en_o is 0, SDA is released and the stored control value is 0.
- R6: Control bit 2 enables a channel and bits 1:0 give its index. ch_en_o[i] is 1 only for index i with bit 2 set. With bit 2 clear, all enables are 0.
- R7: irq_n_o is low whenever any bit of irq_n_i is low, whether or not that channel is selected, and high when all are high.
- R8: A read (R/W = 1) returns a byte. Bit 4+i is 1 when irq_n_i[i] is low, bit 3 is 0, and bits 2:0 are the stored control value. The byte is captured when the read starts.
- R9: Each interrupt bit in the status byte is reported on its own. A bit returns to 0 once its input goes high again.
- R10: When the master NACKs a read byte, the slave stops driving and SDA stays released for the STOP.
- R11: A START arriving in the middle of a byte abandons that byte without storing it and restarts address reception.
- R12: A STOP with no matching write since the last applied selection leaves ch_en_o unchanged. This covers a transaction to another address and a read-only transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line, level as seen on the wire |
| sda_i | input | 1 | Bus data line, level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Low three bits of the slave address |
| irq_n_i | input | 4 | Active-low interrupt inputs, one per channel |
| ch_en_o | output | 4 | One-hot channel enables, all 0 when deselected |
| irq_n_o | output | 1 | Active-low combined interrupt |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and an upper address nibble of 4'b1110. It ties the straps to 3'b101, so the write address byte is 0xEA and a neighbouring address (0xE8) serves as the mismatch case. SCL is bit-banged with a quarter period of ten system clocks. This is far longer than the synchroniser plus edge-detect delay, so every SCL edge is clearly seen. It also makes a START inserted after three data bits, and the open-drain release after a NACK, observable at the pins.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;
  localparam int NUM_CH    = 4;
  localparam int CH_IDX_W  = $clog2(NUM_CH);
  localparam int SEL_W     = CH_IDX_W + 1;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W) + 1;
  localparam int PAD_W     = BYTE_W - NUM_CH - SEL_W;
  localparam int STRAP_W   = 3;
  localparam int FIXED_W   = BYTE_W - 1 - STRAP_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_chsel_sync.sv
module i2c_chsel_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_chsel_slave.sv
module i2c_chsel_slave
  import i2c_chsel_pkg::*;
#(
  parameter logic [FIXED_W-1:0] ADDR_HI = 4'b1110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  status_i,
  output logic               sda_oe_o,
  output logic               wr_stb_o,
  output logic [SEL_W-1:0]   wr_sel_o,
  output logic               start_o,
  output logic               stop_o
);
  slv_state_e           st_q, st_n;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_n;
  logic [BYTE_W-1:0]    sh_q, sh_n;
  logic                 rw_q, rw_n;
  logic                 mack_q, mack_n;
  logic                 oe_q, oe_n;
  logic                 scl_d, sda_d;
  logic                 scl_rise, scl_fall, byte_full;

  assign start_o   = scl_d & scl_i & sda_d & ~sda_i;
  assign stop_o    = scl_d & scl_i & ~sda_d & sda_i;
  assign scl_rise  = ~scl_d & scl_i;
  assign scl_fall  = scl_d & ~scl_i;
  assign byte_full = (cnt_q == BIT_CNT_W'(BYTE_W));

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    rw_n     = rw_q;
    mack_n   = mack_q;
    oe_n     = oe_q;
    wr_stb_o = 1'b0;
    if (start_o) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_o) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise && !byte_full) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            if (sh_q[BYTE_W-1:1] == {ADDR_HI, strap_i}) begin
              rw_n = sh_q[0];
              oe_n = 1'b1;
              st_n = ST_AACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              sh_n = status_i;
              oe_n = ~status_i[BYTE_W-1];
              st_n = ST_RDATA;
            end else begin
              oe_n = 1'b0;
              st_n = ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise && !byte_full) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            oe_n     = 1'b1;
            wr_stb_o = 1'b1;
            st_n     = ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise && !byte_full) begin
            sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              oe_n = ~sh_q[BYTE_W-1];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_n  = status_i;
              oe_n  = ~status_i[BYTE_W-1];
              cnt_n = '0;
              st_n  = ST_RDATA;
            end else begin
              oe_n = 1'b0;
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
      oe_q   <= oe_n;
      scl_d  <= scl_i;
      sda_d  <= sda_i;
    end
  end

  assign sda_oe_o = oe_q;
  assign wr_sel_o = sh_q[SEL_W-1:0];
endmodule

// File: rtl/i2c_chsel_regs.sv
module i2c_chsel_regs
  import i2c_chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              stop_i,
  input  logic [NUM_CH-1:0] irq_n_raw_i,
  input  logic [NUM_CH-1:0] irq_n_sync_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              irq_n_o
);
  logic [SEL_W-1:0] ctrl_q, ctrl_n;
  logic [SEL_W-1:0] act_q, act_n;
  logic             pend_q, pend_n;

  always_comb begin
    ctrl_n = ctrl_q;
    act_n  = act_q;
    pend_n = pend_q;
    if (wr_stb_i) begin
      ctrl_n = wr_sel_i;
      pend_n = 1'b1;
    end else if (stop_i && pend_q) begin
      act_n  = ctrl_q;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      act_q  <= act_n;
      pend_q <= pend_n;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign ch_en_o[g] = act_q[SEL_W-1] & (act_q[CH_IDX_W-1:0] == CH_IDX_W'(g));
  end

  assign status_o = {~irq_n_sync_i, {PAD_W{1'b0}}, ctrl_q};
  assign irq_n_o  = &irq_n_raw_i;
endmodule

// File: rtl/i2c_chsel_ctrl.sv
module i2c_chsel_ctrl
  import i2c_chsel_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [FIXED_W-1:0] ADDR_HI     = 4'b1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [NUM_CH-1:0] irq_n_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              irq_n_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_s;
  logic               scl_s, sda_s;
  logic [NUM_CH-1:0]  irq_s;
  logic [BYTE_W-1:0]  status;
  logic               wr_stb, start_det, stop_det;
  logic [SEL_W-1:0]   wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  i2c_chsel_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2c_chsel_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL({NUM_CH{1'b1}})) u_irq_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(irq_n_i), .q_o(irq_s)
  );

  i2c_chsel_slave #(.ADDR_HI(ADDR_HI)) u_slave (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_s), .sda_i(sda_s), .strap_i(strap_i),
    .status_i(status), .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb), .wr_sel_o(wr_sel),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_chsel_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_stb_i(wr_stb), .wr_sel_i(wr_sel), .stop_i(stop_det),
    .irq_n_raw_i(irq_n_i), .irq_n_sync_i(irq_s), .status_o(status),
    .ch_en_o(ch_en_o), .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/i2c_chsel_ctrl_chk.sv
module i2c_chsel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic [3:0] ch_en,
  input logic [3:0] irq_n_i,
  input logic       irq_n_o
);
  a_r6_onehot_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en));

  a_r4_change_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_en) |-> $past(stop_det));

  a_r7_any_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_i != 4'hF) |-> !irq_n_o);

  a_r1_start_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  a_r10_stop_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r5_reset_idle: assert (ch_en == 4'h0 && !sda_oe);
    end
  end
endmodule

bind i2c_chsel_ctrl i2c_chsel_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .start_det(start_det), .stop_det(stop_det), .ch_en(ch_en_o),
  .irq_n_i(irq_n_i), .irq_n_o(irq_n_o)
);

// File: tb/test_i2c_chsel_ctrl.sv
`timescale 1ns/1ps
module test_i2c_chsel_ctrl;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'hEA, AR = 8'hEB, BADW = 8'hE8, BADR = 8'hE9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_oe;
  logic [3:0] irq_n, ch_en;
  logic       irq_n_o;
  logic       sda_bus;

  int checks = 0, failures = 0;
  bit done = 0;
  string      exp_tag_q[$];
  logic [7:0] exp_val_q[$];
  logic [7:0] got_q[$];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_chsel_ctrl i_i2c_chsel_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(3'b101), .irq_n_i(irq_n), .ch_en_o(ch_en), .irq_n_o(irq_n_o)
  );

  task automatic expect_val(string tag, logic [7:0] v);
    exp_tag_q.push_back(tag);
    exp_val_q.push_back(v);
  endtask

  task automatic observe(logic [7:0] v);
    got_q.push_back(v);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    expect_val(tag, exp);
    observe(got);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_val_q.size() > 0) begin
        string t;
        logic [7:0] e, g;
        t = exp_tag_q.pop_front();
        e = exp_val_q.pop_front();
        g = got_q.pop_front();
        checks++;
        if (g !== e) begin
          failures++;
          $display("FAIL %s actual=0x%02h expected=0x%02h", t, g, e);
        end
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic ack;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; irq_n = 4'hF;
    repeat (5) @(negedge clk);
    chk("R5 ch_en in reset", {4'h0, ch_en}, 8'h00);
    chk("R5 sda released in reset", {7'h0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 irq_n_o idle high", {7'h0, irq_n_o}, 8'h01);

    // R1 R2 R4 R6: write select ch1, deferred to STOP
    i2c_start();
    wr_byte(AW, ack);      chk("R1 address ack", {7'h0, ack}, 8'h00);
    wr_byte(8'hF5, ack);   chk("R2 data ack", {7'h0, ack}, 8'h00);
    chk("R4 no change before stop", {4'h0, ch_en}, 8'h00);
    i2c_stop(); wq();
    chk("R4 R6 ch1 after stop", {4'h0, ch_en}, 8'h02);

    // R3: last byte kept
    i2c_start();
    wr_byte(AW, ack);
    wr_byte(8'h07, ack);
    wr_byte(8'h04, ack);   chk("R2 second data ack", {7'h0, ack}, 8'h00);
    i2c_stop(); wq();
    chk("R3 last byte ch0", {4'h0, ch_en}, 8'h01);

    // R6: bit2 clear deselects
    i2c_start(); wr_byte(AW, ack); wr_byte(8'h03, ack); i2c_stop(); wq();
    chk("R6 deselect", {4'h0, ch_en}, 8'h00);
    i2c_start(); wr_byte(AW, ack); wr_byte(8'h07, ack); i2c_stop(); wq();
    chk("R6 ch3", {4'h0, ch_en}, 8'h08);

    // R1 R12: mismatched address
    i2c_start();
    wr_byte(BADW, ack);    chk("R1 no ack on mismatch", {7'h0, ack}, 8'h01);
    wr_byte(8'h04, ack);
    i2c_stop(); wq();
    chk("R12 foreign write ignored", {4'h0, ch_en}, 8'h08);
    i2c_start(); wr_byte(BADR, ack); i2c_stop(); wq();
    chk("R1 no ack foreign read", {7'h0, ack}, 8'h01);

    // R7 R8 R10: interrupts ch1, ch2
    irq_n = 4'b1001;
    repeat (3) @(negedge clk);
    chk("R7 irq_n_o low", {7'h0, irq_n_o}, 8'h00);
    wq();
    i2c_start();
    wr_byte(AR, ack);      chk("R1 read address ack", {7'h0, ack}, 8'h00);
    rd_byte(1'b0, b);      chk("R8 status ch1 ch2 sel 7", b, 8'h67);
    wq();
    chk("R10 released after nack", {7'h0, sda_oe}, 8'h00);
    i2c_stop(); wq();
    chk("R12 read leaves channel", {4'h0, ch_en}, 8'h08);

    // R9: clear and multiple independent
    irq_n = 4'hF;
    repeat (3) @(negedge clk);
    chk("R7 irq_n_o released", {7'h0, irq_n_o}, 8'h01);
    wq();
    i2c_start(); wr_byte(AR, ack); rd_byte(1'b0, b); i2c_stop();
    chk("R9 status cleared", b, 8'h07);
    irq_n = 4'b0110;
    wq();
    i2c_start(); wr_byte(AR, ack);
    rd_byte(1'b1, b);      chk("R9 ch3 ch0 first byte", b, 8'h97);
    rd_byte(1'b0, b);      chk("R9 ch3 ch0 second byte", b, 8'h97);
    i2c_stop();
    irq_n = 4'b1011;
    repeat (3) @(negedge clk);
    chk("R7 unselected ch2 irq", {7'h0, irq_n_o}, 8'h00);
    irq_n = 4'hF;

    // R11: START mid-byte
    i2c_start();
    wr_byte(AW, ack);
    clk_bit(1'b1, ack); clk_bit(1'b0, ack); clk_bit(1'b1, ack);
    i2c_start();
    wr_byte(AW, ack);      chk("R11 restart address ack", {7'h0, ack}, 8'h00);
    wr_byte(8'h05, ack);
    i2c_stop(); wq();
    chk("R11 new byte applied", {4'h0, ch_en}, 8'h02);
    i2c_start(); wr_byte(AW, ack);
    clk_bit(1'b0, ack); clk_bit(1'b0, ack);
    i2c_start(); wr_byte(AR, ack); rd_byte(1'b0, b); i2c_stop(); wq();
    chk("R11 partial byte not stored", b, 8'h05);

    repeat (20) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule